// File: doc/BRIEF.md
# Character Display Instruction Decoder

This block is the device side of a character display controller. It receives single bus cycles, each a register-select bit, a read/write bit and an 8-bit data byte. It executes the display instruction set against its internal state and memories: an address counter, a choice between display RAM and character RAM, the entry direction, the display, cursor and blink enables, the interface and font options, a display shift offset and a busy flag. The display RAM holds 80 bytes and the character RAM holds 64 bytes. Status reads and data reads answer on a registered read port.

Each accepted instruction or data access keeps the block busy for a fixed time. The time depends on the kind of access and is converted to clock cycles from the clock-frequency parameter. While the block is busy, only status reads are served. Every other cycle that arrives during that time is dropped and counted. A host drives one cycle per access, polls status until bit 7 reads low, and then issues the next access.

Top module: `chardisp_ctrl`

## Requirements
- R1: With RS=0 and R/W=0, the highest set bit of the data byte selects the instruction: bit0 clear, bit1 home, bit2 entry mode {I/D=bit1, SH=bit0}, bit3 display control {display=bit2, cursor=bit1, blink=bit0}, bit4 shift {S/C=bit3, R/L=bit2}, bit5 function set {8-bit bus=bit4, two lines=bit3, tall font=bit2}, bit6 character-RAM address from bits 5:0, bit7 display-RAM address from bits 6:0. Bits below each field are ignored.
- R2: Clear display writes 0x20 into all 80 display-RAM bytes. It sets the address counter to 0, selects display RAM, forces increment mode and zeroes the shift offset.
- R3: Return home sets the address counter and the shift offset to 0 and selects display RAM. The RAM contents are left unchanged.
- R4: busy rises in the cycle after an access is accepted and stays high for a fixed number of cycles: CLK_KHZ*1530/1000 cycles for clear and home, CLK_KHZ*39/1000 for other instructions and CLK_KHZ*43/1000 for data reads and writes.
- R5: A status read (RS=0, R/W=1) is served even while busy. One cycle later it pulses rd_valid with rd_data = {busy, address counter}, and it does not start a busy period.
- R6: A cycle other than a status read that arrives while busy changes no state. It increments ignored_cnt, which saturates at its maximum.
- R7: After a data write or read, the address counter steps by 1: up when I/D=1, down when I/D=0. In two-line mode 0x27 steps up to 0x40 and 0x67 steps up to 0x00, and steps down mirror this. In one-line mode the counter wraps between 0x4F and 0x00. In character RAM it wraps within 6 bits.
- R8: With SH=1, a display-RAM write changes the shift offset: up by one (left) when I/D=1, down by one (right) when I/D=0. The offset wraps modulo 40 in two-line mode and 80 in one-line mode. Reads and character-RAM writes never change the offset.
- R9: In the shift instruction, S/C,R/L of 00 steps the address counter down and 01 steps it up, with the wrap rules of R7. Code 10 moves the offset left (+1) and 11 moves it right (-1), and neither changes the address counter.
- R10: A data read returns the output register and then reloads it from the RAM at the new address. An address set, return home or cursor move reloads the register, but a data write does not. The first read after a write returns the old content, and the first read after reset returns 0x00.
- R11: A data write goes into the RAM chosen by the most recent address-set instruction. cgram_sel reads 1 after a character-RAM address set.
- R12: After reset, busy=0, the address counter is 0, display RAM is selected, I/D=1, SH=0, display, cursor and blink are off, the bus is 8-bit in one-line short-font mode, the offset is 0 and ignored_cnt is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | A bus cycle is presented this clock |
| bus_rs | input | 1 | 0 = instruction/status, 1 = data |
| bus_rw | input | 1 | 0 = write, 1 = read |
| bus_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | Read answer valid |
| rd_data | output | 8 | Status or RAM byte |
| busy | output | 1 | Internal operation in progress |
| addr_cnt | output | 7 | Address counter |
| cgram_sel | output | 1 | Character RAM selected |
| inc_mode | output | 1 | I/D entry direction |
| shift_on_write | output | 1 | SH entry bit |
| disp_on | output | 1 | Display enable |
| cursor_on | output | 1 | Cursor enable |
| blink_on | output | 1 | Blink enable |
| bus_wide | output | 1 | 8-bit interface selected |
| two_line | output | 1 | Two-line mode |
| tall_font | output | 1 | Tall font selected |
| shift_ofs | output | 7 | Display shift offset |
| ignored_cnt | output | ERR_W | Cycles dropped while busy |

## Verification
State fields, rd_valid and rd_data change on the first rising edge after an accepted cycle. The bench samples them at the following falling edge. busy rises at that same edge and falls after exactly the number of cycles given in R4, so the bench counts the high samples one falling edge at a time. The output register reloads two edges after an address change. That reload is always hidden inside the busy window, so the bench's reference model applies the reload at once and only compares it when a later read exposes it. The reference model steps on every rising edge from the same inputs and is compared field by field at every falling edge.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;
  localparam int LINE_LEN = 40;
  localparam int DD_DEPTH = 2 * LINE_LEN;
  localparam int CG_DEPTH = 64;
  localparam int DD_AW    = $clog2(DD_DEPTH);
  localparam int CG_AW    = $clog2(CG_DEPTH);
  localparam logic [6:0] LINE2_BASE = 7'h40;

  typedef enum logic [3:0] {
    OP_NOP, OP_CLEAR, OP_HOME, OP_ENTRY, OP_DISPCTL,
    OP_SHIFT, OP_FUNC, OP_CGADDR, OP_DDADDR
  } op_e;

  // address counter step with line-aware wrapping
  function automatic logic [6:0] ac_next(input logic [6:0] ac, input logic up,
                                         input logic cg, input logic two);
    logic [6:0] l1_last, l2_last, one_last;
    l1_last  = 7'(LINE_LEN - 1);
    l2_last  = LINE2_BASE + 7'(LINE_LEN - 1);
    one_last = 7'(DD_DEPTH - 1);
    if (cg)
      ac_next = {1'b0, up ? ac[5:0] + 6'd1 : ac[5:0] - 6'd1};
    else if (two) begin
      if (up)
        ac_next = (ac == l1_last) ? LINE2_BASE : (ac == l2_last) ? 7'd0 : ac + 7'd1;
      else
        ac_next = (ac == LINE2_BASE) ? l1_last : (ac == 7'd0) ? l2_last : ac - 7'd1;
    end else begin
      if (up) ac_next = (ac >= one_last) ? 7'd0 : ac + 7'd1;
      else    ac_next = (ac == 7'd0) ? one_last : ac - 7'd1;
    end
  endfunction

  // shift offset step, modulo the visible line length
  function automatic logic [6:0] ofs_next(input logic [6:0] ofs, input logic left,
                                          input logic two);
    logic [6:0] len;
    len = two ? 7'(LINE_LEN) : 7'(DD_DEPTH);
    if (left) ofs_next = (ofs >= len - 7'd1) ? 7'd0 : ofs + 7'd1;
    else      ofs_next = (ofs == 7'd0) ? len - 7'd1 : ofs - 7'd1;
  endfunction

  // physical slot of an address: {valid, index}
  function automatic logic [7:0] dd_slot(input logic [6:0] ac, input logic two);
    logic [6:0] rel;
    if (!two)
      dd_slot = {ac < 7'(DD_DEPTH), ac};
    else if (ac >= LINE2_BASE) begin
      rel = ac - LINE2_BASE;
      dd_slot = {rel < 7'(LINE_LEN), rel + 7'(LINE_LEN)};
    end else
      dd_slot = {ac < 7'(LINE_LEN), ac};
  endfunction
endpackage

// File: rtl/chardisp_decode.sv
module chardisp_decode
  import chardisp_pkg::*;
(
  input  logic [7:0] code,
  output op_e        op
);
  always_comb begin
    if      (code[7]) op = OP_DDADDR;
    else if (code[6]) op = OP_CGADDR;
    else if (code[5]) op = OP_FUNC;
    else if (code[4]) op = OP_SHIFT;
    else if (code[3]) op = OP_DISPCTL;
    else if (code[2]) op = OP_ENTRY;
    else if (code[1]) op = OP_HOME;
    else if (code[0]) op = OP_CLEAR;
    else              op = OP_NOP;
  end
endmodule

// File: rtl/chardisp_busy.sv
module chardisp_busy #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (load) begin
      cnt  <= len;
      busy <= 1'b1;
    end else if (cnt != '0) begin
      cnt  <= cnt - 1'b1;
      busy <= (cnt != CW'(1));
    end
  end
endmodule

// File: rtl/chardisp_ram.sv
module chardisp_ram #(
  parameter int DEPTH = 80,
  parameter int AW    = 7,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/chardisp_ctrl.sv
module chardisp_ctrl
  import chardisp_pkg::*;
#(
  parameter int CLK_KHZ = 50000,
  parameter int ERR_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_valid,
  input  logic             bus_rs,
  input  logic             bus_rw,
  input  logic [7:0]       bus_wdata,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic [6:0]       addr_cnt,
  output logic             cgram_sel,
  output logic             inc_mode,
  output logic             shift_on_write,
  output logic             disp_on,
  output logic             cursor_on,
  output logic             blink_on,
  output logic             bus_wide,
  output logic             two_line,
  output logic             tall_font,
  output logic [6:0]       shift_ofs,
  output logic [ERR_W-1:0] ignored_cnt
);
  localparam int CLR_RAW = CLK_KHZ * 1530 / 1000;
  localparam int INS_RAW = CLK_KHZ * 39 / 1000;
  localparam int DAT_RAW = CLK_KHZ * 43 / 1000;
  localparam int CLR_CYC = (CLR_RAW > DD_DEPTH) ? CLR_RAW : DD_DEPTH + 1;
  localparam int INS_CYC = (INS_RAW > 3) ? INS_RAW : 3;
  localparam int DAT_CYC = (DAT_RAW > 3) ? DAT_RAW : 3;
  localparam int BW      = $clog2(CLR_CYC + 1);

  op_e op;
  chardisp_decode u_dec (.code(bus_wdata), .op(op));

  logic stat_cyc, ins_acc, stat_acc, dwr_acc, drd_acc, ign;
  always_comb begin
    stat_cyc = bus_valid & ~bus_rs & bus_rw;
    ins_acc  = bus_valid & ~busy & ~bus_rs & ~bus_rw;
    stat_acc = stat_cyc;
    dwr_acc  = bus_valid & ~busy & bus_rs & ~bus_rw;
    drd_acc  = bus_valid & ~busy & bus_rs & bus_rw;
    ign      = bus_valid & busy & ~stat_cyc;
  end

  logic          busy_load;
  logic [BW-1:0] busy_len;
  always_comb begin
    busy_load = (ins_acc & (op != OP_NOP)) | dwr_acc | drd_acc;
    if (ins_acc && (op == OP_CLEAR || op == OP_HOME)) busy_len = BW'(CLR_CYC);
    else if (ins_acc)                                 busy_len = BW'(INS_CYC);
    else                                              busy_len = BW'(DAT_CYC);
  end

  chardisp_busy #(.CW(BW)) u_busy (
    .clk(clk), .rst(rst), .load(busy_load), .len(busy_len), .busy(busy)
  );

  // memories and their ports
  logic [7:0]       slot;
  logic             slot_ok;
  logic             clr_act;
  logic [DD_AW-1:0] clr_idx;
  logic             dd_we, cg_we;
  logic [DD_AW-1:0] dd_waddr, dd_raddr;
  logic [7:0]       dd_wdata, dd_rdata, cg_rdata;

  always_comb begin
    slot     = dd_slot(addr_cnt, two_line);
    slot_ok  = slot[7];
    dd_we    = clr_act | (dwr_acc & ~cgram_sel & slot_ok);
    dd_waddr = clr_act ? clr_idx : DD_AW'(slot[6:0]);
    dd_wdata = clr_act ? 8'h20 : bus_wdata;
    dd_raddr = slot_ok ? DD_AW'(slot[6:0]) : '0;
    cg_we    = dwr_acc & cgram_sel;
  end

  chardisp_ram #(.DEPTH(DD_DEPTH), .AW(DD_AW), .DW(8)) u_dd (
    .clk(clk), .we(dd_we), .waddr(dd_waddr), .wdata(dd_wdata),
    .raddr(dd_raddr), .rdata(dd_rdata)
  );

  chardisp_ram #(.DEPTH(CG_DEPTH), .AW(CG_AW), .DW(8)) u_cg (
    .clk(clk), .we(cg_we), .waddr(addr_cnt[CG_AW-1:0]), .wdata(bus_wdata),
    .raddr(addr_cnt[CG_AW-1:0]), .rdata(cg_rdata)
  );

  logic       fetch_s1, fetch_s2;
  logic [7:0] out_reg;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid       <= 1'b0;
      rd_data        <= 8'h00;
      addr_cnt       <= 7'd0;
      cgram_sel      <= 1'b0;
      inc_mode       <= 1'b1;
      shift_on_write <= 1'b0;
      disp_on        <= 1'b0;
      cursor_on      <= 1'b0;
      blink_on       <= 1'b0;
      bus_wide       <= 1'b1;
      two_line       <= 1'b0;
      tall_font      <= 1'b0;
      shift_ofs      <= 7'd0;
      ignored_cnt    <= '0;
      clr_act        <= 1'b0;
      clr_idx        <= '0;
      fetch_s1       <= 1'b0;
      fetch_s2       <= 1'b0;
      out_reg        <= 8'h00;
    end else begin
      rd_valid <= 1'b0;
      fetch_s1 <= 1'b0;
      fetch_s2 <= fetch_s1;
      if (fetch_s2) out_reg <= cgram_sel ? cg_rdata : (slot_ok ? dd_rdata : 8'h20);

      if (clr_act) begin
        if (clr_idx == DD_AW'(DD_DEPTH - 1)) clr_act <= 1'b0;
        clr_idx <= clr_idx + 1'b1;
      end

      if (ign && ignored_cnt != '1) ignored_cnt <= ignored_cnt + 1'b1;

      if (stat_acc) begin
        rd_valid <= 1'b1;
        rd_data  <= {busy, addr_cnt};
      end

      if (dwr_acc) begin
        addr_cnt <= ac_next(addr_cnt, inc_mode, cgram_sel, two_line);
        if (shift_on_write && !cgram_sel)
          shift_ofs <= ofs_next(shift_ofs, inc_mode, two_line);
      end

      if (drd_acc) begin
        rd_valid <= 1'b1;
        rd_data  <= out_reg;
        addr_cnt <= ac_next(addr_cnt, inc_mode, cgram_sel, two_line);
        fetch_s1 <= 1'b1;
      end

      if (ins_acc) begin
        unique case (op)
          OP_CLEAR: begin
            addr_cnt  <= 7'd0;
            cgram_sel <= 1'b0;
            inc_mode  <= 1'b1;
            shift_ofs <= 7'd0;
            clr_act   <= 1'b1;
            clr_idx   <= '0;
          end
          OP_HOME: begin
            addr_cnt  <= 7'd0;
            cgram_sel <= 1'b0;
            shift_ofs <= 7'd0;
            fetch_s1  <= 1'b1;
          end
          OP_ENTRY: begin
            inc_mode       <= bus_wdata[1];
            shift_on_write <= bus_wdata[0];
          end
          OP_DISPCTL: begin
            disp_on   <= bus_wdata[2];
            cursor_on <= bus_wdata[1];
            blink_on  <= bus_wdata[0];
          end
          OP_SHIFT: begin
            if (bus_wdata[3])
              shift_ofs <= ofs_next(shift_ofs, ~bus_wdata[2], two_line);
            else begin
              addr_cnt <= ac_next(addr_cnt, bus_wdata[2], cgram_sel, two_line);
              fetch_s1 <= 1'b1;
            end
          end
          OP_FUNC: begin
            bus_wide  <= bus_wdata[4];
            two_line  <= bus_wdata[3];
            tall_font <= bus_wdata[2];
          end
          OP_CGADDR: begin
            addr_cnt  <= {1'b0, bus_wdata[5:0]};
            cgram_sel <= 1'b1;
            fetch_s1  <= 1'b1;
          end
          OP_DDADDR: begin
            addr_cnt  <= bus_wdata[6:0];
            cgram_sel <= 1'b0;
            fetch_s1  <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/chardisp_ctrl_chk.sv
module chardisp_ctrl_chk #(
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_valid,
  input logic             bus_rs,
  input logic             bus_rw,
  input logic [7:0]       bus_wdata,
  input logic             rd_valid,
  input logic             busy,
  input logic [6:0]       addr_cnt,
  input logic             cgram_sel,
  input logic             inc_mode,
  input logic             disp_on,
  input logic [6:0]       shift_ofs,
  input logic [ERR_W-1:0] ignored_cnt
);
  // R5
  stat_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_rs && bus_rw) |=> rd_valid);

  // R4
  busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(bus_valid));

  // R6
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && busy && bus_rs) |=> $stable(addr_cnt));

  // R6
  drop_count_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && busy && !(!bus_rs && bus_rw) && ignored_cnt != '1)
      |=> (ignored_cnt - $past(ignored_cnt)) == ERR_W'(1));

  // R2
  clear_effect_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !busy && !bus_rs && !bus_rw && bus_wdata == 8'h01)
      |=> (addr_cnt == 7'd0 && inc_mode && busy && !cgram_sel && shift_ofs == 7'd0));

  // R8
  read_noshift_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !busy && bus_rs && bus_rw) |=> $stable(shift_ofs));

  // R1
  disp_ctl_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !busy && !bus_rs && !bus_rw && bus_wdata[7:3] == 5'b00001)
      |=> disp_on == $past(bus_wdata[2]));
endmodule

bind chardisp_ctrl chardisp_ctrl_chk #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_rs(bus_rs), .bus_rw(bus_rw),
  .bus_wdata(bus_wdata), .rd_valid(rd_valid), .busy(busy), .addr_cnt(addr_cnt),
  .cgram_sel(cgram_sel), .inc_mode(inc_mode), .disp_on(disp_on),
  .shift_ofs(shift_ofs), .ignored_cnt(ignored_cnt)
);

// File: tb/tb_chardisp_ctrl.sv
module tb_chardisp_ctrl;
  localparam int CLK_KHZ = 1000;
  localparam int ERR_W   = 8;
  localparam int CLR_N   = CLK_KHZ * 1530 / 1000;
  localparam int INS_N   = CLK_KHZ * 39 / 1000;
  localparam int DAT_N   = CLK_KHZ * 43 / 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic       bus_valid = 1'b0, bus_rs = 1'b0, bus_rw = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic       rd_valid, busy, cgram_sel, inc_mode, shift_on_write;
  logic       disp_on, cursor_on, blink_on, bus_wide, two_line, tall_font;
  logic [7:0] rd_data;
  logic [6:0] addr_cnt, shift_ofs;
  logic [ERR_W-1:0] ignored_cnt;

  chardisp_ctrl #(.CLK_KHZ(CLK_KHZ), .ERR_W(ERR_W)) dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_rs(bus_rs), .bus_rw(bus_rw),
    .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
    .addr_cnt(addr_cnt), .cgram_sel(cgram_sel), .inc_mode(inc_mode),
    .shift_on_write(shift_on_write), .disp_on(disp_on), .cursor_on(cursor_on),
    .blink_on(blink_on), .bus_wide(bus_wide), .two_line(two_line),
    .tall_font(tall_font), .shift_ofs(shift_ofs), .ignored_cnt(ignored_cnt)
  );

  int checks = 0, errors = 0;
  logic [7:0] last_rd;

  task automatic chk(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_ac, m_cg, m_inc, m_sh, m_d, m_c, m_b, m_wide, m_two, m_tall;
  int m_ofs, m_busy, m_ign, m_rdv, m_rd, m_rdstat, m_out;
  int dd [80];
  int cg [64];

  function automatic int mstep(int ac, int up);
    int p;
    if (m_cg != 0) return up ? (ac + 1) % 64 : (ac + 63) % 64;
    if (m_two == 0) return up ? (ac + 1) % 80 : (ac + 79) % 80;
    p = (ac >= 64) ? 40 + ac - 64 : ac;
    p = up ? (p + 1) % 80 : (p + 79) % 80;
    return (p >= 40) ? 64 + p - 40 : p;
  endfunction

  function automatic int mslot(int ac);
    if (m_two != 0 && ac >= 64) return ac - 64 + 40;
    return ac;
  endfunction

  function automatic int mofs(int o, int left);
    int len;
    len = (m_two != 0) ? 40 : 80;
    if (left != 0) return (o + 1 >= len) ? 0 : o + 1;
    return (o == 0) ? len - 1 : o - 1;
  endfunction

  task automatic mfetch();
    m_out = (m_cg != 0) ? cg[m_ac % 64] : dd[mslot(m_ac)];
  endtask

  always @(posedge clk) begin
    int d;
    bit loaded;
    if (rst) begin
      m_ac = 0; m_cg = 0; m_inc = 1; m_sh = 0; m_d = 0; m_c = 0; m_b = 0;
      m_wide = 1; m_two = 0; m_tall = 0; m_ofs = 0; m_busy = 0; m_ign = 0;
      m_rdv = 0; m_rd = 0; m_rdstat = 0; m_out = 0;
      foreach (dd[i]) dd[i] = -1;
      foreach (cg[i]) cg[i] = -1;
    end else begin
      d = int'(bus_wdata);
      loaded = 0;
      m_rdv = 0;
      if (bus_valid && !bus_rs && bus_rw) begin
        m_rdv = 1; m_rdstat = 1;
        m_rd = (m_busy > 0 ? 128 : 0) + m_ac;
      end else if (bus_valid && m_busy > 0) begin
        if (m_ign < 255) m_ign++;
      end else if (bus_valid && bus_rs && !bus_rw) begin
        if (m_cg != 0) cg[m_ac % 64] = d;
        else dd[mslot(m_ac)] = d;
        if (m_sh != 0 && m_cg == 0) m_ofs = mofs(m_ofs, m_inc);
        m_ac = mstep(m_ac, m_inc);
        m_busy = DAT_N; loaded = 1;
      end else if (bus_valid && bus_rs && bus_rw) begin
        m_rdv = 1; m_rdstat = 0; m_rd = m_out;
        m_ac = mstep(m_ac, m_inc);
        mfetch();
        m_busy = DAT_N; loaded = 1;
      end else if (bus_valid && d != 0) begin
        loaded = 1;
        m_busy = INS_N;
        if (d >= 128) begin m_ac = d - 128; m_cg = 0; mfetch(); end
        else if (d >= 64) begin m_ac = d - 64; m_cg = 1; mfetch(); end
        else if (d >= 32) begin m_wide = (d >> 4) & 1; m_two = (d >> 3) & 1; m_tall = (d >> 2) & 1; end
        else if (d >= 16) begin
          if (((d >> 3) & 1) != 0) m_ofs = mofs(m_ofs, ((d >> 2) & 1) == 0);
          else begin m_ac = mstep(m_ac, (d >> 2) & 1); mfetch(); end
        end
        else if (d >= 8) begin m_d = (d >> 2) & 1; m_c = (d >> 1) & 1; m_b = d & 1; end
        else if (d >= 4) begin m_inc = (d >> 1) & 1; m_sh = d & 1; end
        else if (d >= 2) begin m_ac = 0; m_cg = 0; m_ofs = 0; mfetch(); m_busy = CLR_N; end
        else begin
          foreach (dd[i]) dd[i] = 32;
          m_ac = 0; m_cg = 0; m_inc = 1; m_ofs = 0; m_busy = CLR_N;
        end
      end
      if (!loaded && m_busy > 0) m_busy--;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R4", int'(busy), (m_busy > 0) ? 1 : 0, "busy");
      chk("R7", int'(addr_cnt), m_ac, "addr_cnt");
      chk("R11", int'(cgram_sel), m_cg, "cgram_sel");
      chk("R1", int'(inc_mode), m_inc, "inc_mode");
      chk("R1", int'(shift_on_write), m_sh, "shift_on_write");
      chk("R1", int'({disp_on, cursor_on, blink_on}), m_d * 4 + m_c * 2 + m_b, "disp bits");
      chk("R1", int'({bus_wide, two_line, tall_font}), m_wide * 4 + m_two * 2 + m_tall, "func bits");
      chk("R8", int'(shift_ofs), m_ofs, "shift_ofs");
      chk("R6", int'(ignored_cnt), m_ign, "ignored_cnt");
      chk(m_rdstat ? "R5" : "R10", int'(rd_valid), m_rdv, "rd_valid");
      if (m_rdv != 0) chk(m_rdstat ? "R5" : "R10", int'(rd_data), m_rd, "rd_data");
    end
  end

  // ---------------- stimulus ----------------
  task automatic bus(input bit rs, input bit rw, input logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_rs = rs; bus_rw = rw; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0;
    last_rd = rd_data;
  endtask

  task automatic idle();
    while (busy) @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] d);
    bus(1'b0, 1'b0, d); idle();
  endtask

  task automatic wr(input logic [7:0] d);
    bus(1'b1, 1'b0, d); idle();
  endtask

  task automatic rd(input int exp, input string tag);
    bus(1'b1, 1'b1, 8'h00);
    chk(tag, int'(last_rd), exp, "data read");
    idle();
  endtask

  task automatic stat(input int exp, input string tag);
    bus(1'b0, 1'b1, 8'h00);
    chk(tag, int'(last_rd), exp, "status read");
  endtask

  task automatic busy_len(input bit rs, input logic [7:0] d, input int exp, input string tag);
    int n;
    n = 0;
    bus(rs, 1'b0, d);
    while (busy) begin n++; @(negedge clk); end
    chk(tag, n, exp, "busy cycles");
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12", int'(busy), 0, "reset busy");
    chk("R12", int'(addr_cnt), 0, "reset addr");
    chk("R12", int'({cgram_sel, inc_mode, shift_on_write}), 3'b010, "reset entry");
    chk("R12", int'({disp_on, cursor_on, blink_on, bus_wide, two_line, tall_font}), 6'b000100, "reset flags");
    chk("R12", int'(shift_ofs) + int'(ignored_cnt), 0, "reset ofs/ign");
    rd(8'h00, "R10");                      // first read after reset is stale 0x00
    idle();
    busy_len(1'b0, 8'h01, CLR_N, "R4");     // R2 clear, long busy
    busy_len(1'b0, 8'h38, INS_N, "R4");     // two-line function set
    cmd(8'h06);
    cmd(8'h0F);
    cmd(8'hA6);
    busy_len(1'b1, 8'h41, DAT_N, "R4");
    wr(8'h42);
    stat(8'h40, "R7");                       // 0x27 -> 0x40
    wr(8'h43);
    cmd(8'hA6);
    rd(8'h41, "R10"); rd(8'h42, "R10"); rd(8'h43, "R7");
    cmd(8'h80);
    rd(8'h20, "R2");                         // cleared content
    cmd(8'h80);
    wr(8'h55);
    rd(8'h20, "R10");                        // first read after a write: stale
    cmd(8'hE7); wr(8'h11);
    stat(8'h00, "R7");                       // 0x67 -> 0x00
    cmd(8'h04); wr(8'h12);
    stat(8'h67, "R7");                       // 0x00 -> 0x67
    cmd(8'hC0); wr(8'h13);
    stat(8'h27, "R7");                       // 0x40 -> 0x27
    cmd(8'h07); wr(8'h14);
    chk("R8", int'(shift_ofs), 1, "SH left");
    cmd(8'h05); wr(8'h15); wr(8'h16);
    chk("R8", int'(shift_ofs), 39, "SH right wrap");
    rd(8'h43, "R10");
    chk("R8", int'(shift_ofs), 39, "read no shift");
    cmd(8'h10); stat(8'h24, "R9");
    cmd(8'h14); stat(8'h25, "R9");
    cmd(8'h18);
    chk("R9", int'(shift_ofs), 0, "display left");
    stat(8'h25, "R9");
    cmd(8'h1C); cmd(8'h1C);
    chk("R9", int'(shift_ofs), 38, "display right");
    cmd(8'h02);
    chk("R3", int'(addr_cnt) + int'(shift_ofs), 0, "home");
    rd(8'h12, "R3");
    cmd(8'h06); cmd(8'h7F); wr(8'h1F);
    stat(8'h00, "R7");                       // 6-bit character RAM wrap
    cmd(8'h7F);
    chk("R11", int'(cgram_sel), 1, "cg select");
    rd(8'h1F, "R11");
    cmd(8'h07); cmd(8'h40); wr(8'h0A);
    chk("R8", int'(shift_ofs), 0, "cg write no shift");
    bus(1'b0, 1'b0, 8'h0C);
    bus(1'b1, 1'b0, 8'h99);
    chk("R6", int'(ignored_cnt), 1, "ignored count");
    stat(8'h81, "R5");                       // busy bit in status
    idle();
    stat(8'h01, "R6");                       // dropped write left AC alone
    chk("R1", int'({disp_on, cursor_on, blink_on}), 3'b100, "display control");
    cmd(8'h30);
    chk("R1", int'(two_line), 0, "one-line");
    cmd(8'hCF); wr(8'h77);
    stat(8'h00, "R7");                       // 0x4F -> 0x00
    cmd(8'h04); wr(8'h78);
    stat(8'h4F, "R7");
    cmd(8'h3F);
    chk("R1", int'({bus_wide, two_line, tall_font}), 3'b111, "don't-care low bits");
    busy_len(1'b0, 8'h03, CLR_N, "R1");      // 0x03 decodes as home
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule